// File: doc/BRIEF.md
# Bus Low-Address Byte Latch

This block recovers the low address byte from a bus port that carries the address and the data at different times. During the address phase the bus master raises an address strobe and drives the low address byte on the shared port. The block stores that byte while the strobe is high. When the strobe drops, it keeps the byte so that peripherals still see a stable low address during the data phase, when the same port carries data. The stored byte is joined with the live high address byte to form a full address for peripheral selection.

The design is synchronous. A system clock samples the strobe and the shared port on every rising edge. While the strobe is sampled high, the stored byte follows the port, so the latch is transparent. While the strobe is sampled low, the stored byte holds. A one-cycle pulse marks each sampled falling edge of the strobe. There is no tri-state driver. An active-low output enable instead sets a "driven" flag, and while the output is not driven the value on the low-byte output reads zero. The stored byte is not affected by the output enable. In the usual address-latch use the output enable is held low, so the output is always driven.

Top module: `adl_addr_latch`

## Requirements
- R1: While `rst` is high at a rising clock edge, the stored byte is cleared to 00h and, after that edge, `lo_q` = 00h, `lo_valid` = 0, `addr_full` = 0000h and `strobe_fell` = 0.
- R2: When `addr_strobe` is 1 at a rising edge, the stored byte takes the value of `ad_in` at that edge. With `oe_n` = 0, the value appears on `lo_q` and on `addr_full[7:0]` right after that edge.
- R3: When `addr_strobe` is 0 at a rising edge, the stored byte keeps its value whatever `ad_in` carries.
- R4: After the strobe falls, the outputs keep showing the last byte sampled while the strobe was high. For example, 55h stays on `lo_q` while the port carries AAh in the data phase.
- R5: When `oe_n` is 1 at a rising edge, after that edge `lo_valid` = 0 and `lo_q` = 00h. When `oe_n` is 0 at a rising edge, `lo_valid` = 1 and `lo_q` shows the stored byte.
- R6: The stored byte loads and holds under R2 and R3 whatever the value of `oe_n`. A byte loaded while the output is not driven appears once `oe_n` returns to 0.
- R7: After each rising edge out of reset, `addr_full[15:8]` equals `hi_addr` sampled at that edge and `addr_full[7:0]` equals the stored byte. This holds whatever the value of `oe_n`.
- R8: `strobe_fell` is 1 for exactly the one cycle after an edge where `addr_strobe` is 0 and was 1 at the edge before. It stays 0 on rising strobe edges and on steady levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ad_in | input | 8 | Shared address/data port, low byte |
| addr_strobe | input | 1 | Address strobe; high = transparent |
| oe_n | input | 1 | Active-low output enable |
| hi_addr | input | 8 | Live high address byte |
| lo_q | output | 8 | Latched low address byte, 00h when not driven |
| lo_valid | output | 1 | 1 when `lo_q` is driven |
| addr_full | output | 16 | High byte joined with latched low byte |
| strobe_fell | output | 1 | One-cycle pulse after a strobe falling edge |

## Verification
The bench sends 55h followed by AAh on the port around a strobe fall. A latch that samples one cycle too late would show AAh in the data phase. It also loads a byte while the output is disabled and then re-enables the output. A design that gated storage with the output enable would bring back the old byte. The high byte is changed while the low byte holds, which exposes any design that registers the high byte only on strobe activity. The bench also raises the strobe and checks that no falling-edge pulse follows, which catches an edge detector with the wrong polarity.

// File: rtl/adl_pkg.sv
package adl_pkg;
  localparam int unsigned LO_W_DEF = 8;
  localparam int unsigned HI_W_DEF = 8;

  typedef enum logic [1:0] {
    STB_IDLE = 2'b00,
    STB_RISE = 2'b01,
    STB_HIGH = 2'b11,
    STB_FALL = 2'b10
  } stb_phase_e;

  function automatic stb_phase_e stb_phase(input logic prev, input logic now);
    return stb_phase_e'({prev, now});
  endfunction
endpackage

// File: rtl/adl_edge_det.sv
module adl_edge_det
  import adl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic fell_q
);
  logic       strobe_d;
  stb_phase_e phase;

  always_comb phase = stb_phase(strobe_d, strobe);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_d <= 1'b0;
      fell_q   <= 1'b0;
    end else begin
      strobe_d <= strobe;
      fell_q   <= (phase == STB_FALL);
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fell_q |=> !fell_q) else $error("pulse longer than one cycle"); // R8
endmodule

// File: rtl/adl_store.sv
module adl_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb nxt[b] = load ? din[b] : q[b];
    always_ff @(posedge clk) begin
      if (rst) q[b] <= 1'b0;
      else     q[b] <= nxt[b];
    end
  end

  AST_FOLLOW_HIGH: assert property (@(posedge clk) disable iff (rst)
    (load) |=> (q == $past(din))) else $error("no follow"); // R2
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> (q == $past(q))) else $error("no hold"); // R3
endmodule

// File: rtl/adl_out_stage.sv
module adl_out_stage #(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 8,
  localparam int unsigned A_W = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            oe_n,
  input  logic [LO_W-1:0] lo_nxt,
  input  logic [HI_W-1:0] hi_in,
  output logic [LO_W-1:0] lo_q,
  output logic            lo_valid,
  output logic [A_W-1:0]  addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q     <= '0;
      lo_valid <= 1'b0;
      addr_q   <= '0;
    end else begin
      lo_valid <= ~oe_n;
      lo_q     <= oe_n ? '0 : lo_nxt;
      addr_q   <= {hi_in, lo_nxt};
    end
  end

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!lo_valid) |-> (lo_q == '0)) else $error("value while undriven"); // R5
  AST_LOW_MATCH: assert property (@(posedge clk) disable iff (rst)
    (lo_valid) |-> (lo_q == addr_q[LO_W-1:0])) else $error("low byte mismatch"); // R7
endmodule

// File: rtl/adl_addr_latch.sv
module adl_addr_latch
  import adl_pkg::*;
#(
  parameter int unsigned LO_W = LO_W_DEF,
  parameter int unsigned HI_W = HI_W_DEF,
  localparam int unsigned A_W = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LO_W-1:0] ad_in,
  input  logic            addr_strobe,
  input  logic            oe_n,
  input  logic [HI_W-1:0] hi_addr,
  output logic [LO_W-1:0] lo_q,
  output logic            lo_valid,
  output logic [A_W-1:0]  addr_full,
  output logic            strobe_fell
);
  logic [LO_W-1:0] st_nxt;
  logic [LO_W-1:0] st_q;

  adl_store #(.W(LO_W)) u_store (
    .clk(clk), .rst(rst), .load(addr_strobe), .din(ad_in),
    .nxt(st_nxt), .q(st_q)
  );

  adl_out_stage #(.LO_W(LO_W), .HI_W(HI_W)) u_out (
    .clk(clk), .rst(rst), .oe_n(oe_n), .lo_nxt(st_nxt), .hi_in(hi_addr),
    .lo_q(lo_q), .lo_valid(lo_valid), .addr_q(addr_full)
  );

  adl_edge_det u_edge (
    .clk(clk), .rst(rst), .strobe(addr_strobe), .fell_q(strobe_fell)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (lo_q == '0 && !lo_valid && addr_full == '0 && !strobe_fell)) else $error("reset"); // R1
  AST_OE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (lo_valid == !$past(oe_n))) else $error("oe flag"); // R5
  AST_HI_LIVE: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (addr_full[A_W-1:LO_W] == $past(hi_addr))) else $error("hi byte"); // R7
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    strobe_fell |-> !$past(addr_strobe)) else $error("pulse without fall"); // R8
  AST_HOLD_FALL: assert property (@(posedge clk) disable iff (rst)
    (!rst && !addr_strobe) |=> (addr_full[LO_W-1:0] == $past(st_q))) else $error("fall hold"); // R4
endmodule

// File: tb/adl_addr_latch_test.sv
`timescale 1ns/1ps
module adl_addr_latch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ad_in = 8'h00;
  logic        addr_strobe = 1'b0;
  logic        oe_n = 1'b0;
  logic [7:0]  hi_addr = 8'h00;
  logic [7:0]  lo_q;
  logic        lo_valid;
  logic [15:0] addr_full;
  logic        strobe_fell;
  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  adl_addr_latch uut (
    .clk(clk), .rst(rst), .ad_in(ad_in), .addr_strobe(addr_strobe),
    .oe_n(oe_n), .hi_addr(hi_addr), .lo_q(lo_q), .lo_valid(lo_valid),
    .addr_full(addr_full), .strobe_fell(strobe_fell)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; addr_strobe = 1'b1; ad_in = 8'hA5; hi_addr = 8'h77;
    step(); step();
    chk("R1 lo_q", lo_q, 0);
    chk("R1 lo_valid", lo_valid, 0);
    chk("R1 addr_full", addr_full, 0);
    chk("R1 strobe_fell", strobe_fell, 0);
    addr_strobe = 1'b0; rst = 1'b0; hi_addr = 8'h00;
    step();
    chk("R1 stored cleared", lo_q, 8'h00);
  endtask

  task automatic t_follow();
    oe_n = 1'b0; addr_strobe = 1'b1; ad_in = 8'h12;
    step();
    chk("R2 follow 12", lo_q, 8'h12);
    chk("R5 driven", lo_valid, 1);
    ad_in = 8'h34;
    step();
    chk("R2 follow 34", lo_q, 8'h34);
    chk("R2 addr low", addr_full[7:0], 8'h34);
  endtask

  task automatic t_hold();
    addr_strobe = 1'b0; ad_in = 8'hFF;
    step();
    chk("R3 hold vs FF", lo_q, 8'h34);
    chk("R8 pulse after fall", strobe_fell, 1);
    ad_in = 8'h00;
    step();
    chk("R3 hold vs 00", lo_q, 8'h34);
    chk("R8 no pulse steady low", strobe_fell, 0);
  endtask

  task automatic t_data_phase();
    hi_addr = 8'hFF; addr_strobe = 1'b1; ad_in = 8'h55;
    step();
    chk("R8 no pulse on rise", strobe_fell, 0);
    addr_strobe = 1'b0; ad_in = 8'hAA;
    step();
    chk("R4 data phase low byte", lo_q, 8'h55);
    chk("R4 data phase addr", addr_full, 16'hFF55);
    step();
    chk("R4 still 55", lo_q, 8'h55);
  endtask

  task automatic t_hiz();
    oe_n = 1'b1;
    step();
    chk("R5 undriven flag", lo_valid, 0);
    chk("R5 undriven value", lo_q, 8'h00);
    chk("R7 addr kept undriven", addr_full, 16'hFF55);
    addr_strobe = 1'b1; ad_in = 8'h3C;
    step();
    chk("R6 load while undriven addr", addr_full, 16'hFF3C);
    chk("R6 still undriven", lo_valid, 0);
    addr_strobe = 1'b0; ad_in = 8'h99;
    step();
    oe_n = 1'b0;
    step();
    chk("R6 reenable shows 3C", lo_q, 8'h3C);
    chk("R5 driven again", lo_valid, 1);
  endtask

  task automatic t_hi_live();
    hi_addr = 8'h12;
    step();
    chk("R7 live hi 12", addr_full, 16'h123C);
    hi_addr = 8'hC0;
    step();
    chk("R7 live hi C0", addr_full, 16'hC03C);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_follow();
    t_hold();
    t_data_phase();
    t_hiz();
    t_hi_live();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule